// File: doc/BRIEF.md
# Six-Button Gamepad Port Read Multiplexer

This block forms the byte a CPU sees when it reads a game-controller port. A pad with up to twelve buttons is attached to the port. Only six button lines can be presented at once, so the block picks which buttons appear. The choice depends on the port's select line (TH, bit 6 of the port data register), on whether six-button support is enabled, and on a 2-bit select-phase count that external logic advances. Bits that the CPU has configured as outputs read back what the CPU last wrote to the data register. Bit 7 is always handled as an output.

The read path is purely combinational. Each value is a snapshot of the current inputs, so there is nothing to stream and no valid/ready handshake. The read data is valid in the same cycle as the inputs and can never be back-pressured. The phase input is held by its owner for the duration of a read. The block does not advance the phase.

Top module: `padmux_port_rd`

## Requirements
- R1: Button inputs are active high, packed into `btn_i[11:0]` with bit 11 down to bit 0 carrying Mode, X, Y, Z, Start, A, C, B, Right, Left, Down, Up. A pressed button appears on the port as 0 and a released one as 1.
- R2: Each port bit whose direction bit `dir_reg_i[i]` is 1 reads the matching bit of `data_reg_i`, regardless of button state.
- R3: Bit 7 always reads `data_reg_i[7]`, whatever `dir_reg_i[7]` holds.
- R4: With TH (`data_reg_i[6]`) high in standard encoding, input bits 5 down to 0 read C, B, Right, Left, Down, Up.
- R5: With TH low in standard encoding, input bits 5:4 read Start, A. Bits 3:2 read 0. Bits 1:0 read Down, Up.
- R6: With six-button enabled, phase 2 and TH low, input bits 5:4 read Start, A and bits 3:0 read 0.
- R7: With six-button enabled, phase 3 and TH high, input bits 5:4 read C, B and bits 3:0 read Mode, X, Y, Z, with Mode in bit 3 and Z in bit 0.
- R8: With six-button enabled, phase 3 and TH low, input bits 5:4 read Start, A and bits 3:0 read 1.
- R9: Standard encoding (R4/R5) is used whenever six-button is disabled, in phases 0 and 1, and in phase 2 with TH high.
- R10: When `dir_reg_i[6]` is 0, bit 6 reads 0. The TH value used for selection is still `data_reg_i[6]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| btn_i | input | 12 | Active-high button states, Mode..Up from MSB to LSB |
| data_reg_i | input | 8 | Port data register; bit 6 is the TH select |
| dir_reg_i | input | 8 | Port direction register, 1 = output |
| six_btn_en_i | input | 1 | Enables six-button phase decoding |
| phase_i | input | 2 | Select-phase count from the phase sequencer |
| port_rd_o | output | 8 | Byte returned to a CPU read of the port |

## Verification
Random button words, register values, phases and enable settings are mixed with directed cases. The directed cases include all-pressed and none-pressed pads, a single pressed button walked across every position, and each phase with TH at both levels. The walking button separates the bit mapping of each encoding, so a swapped or misplaced button is caught. The zero and all-ones nibbles of phases 2 and 3 are separated from genuine button data by using pads where those buttons are released. Direction masks that mark TH as input or output, and that flip bit 7, show whether register readback overrides button data.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int BTN_W   = 12;
  localparam int PORT_W  = 8;
  localparam int FIELD_W = 6;
  localparam int PHASE_W = 2;

  typedef struct packed {
    logic mode;
    logic x;
    logic y;
    logic z;
    logic start;
    logic a;
    logic c;
    logic b;
    logic right;
    logic left;
    logic down;
    logic up;
  } pad_btn_t;

  typedef enum logic [2:0] {
    SEL_STD_HI,
    SEL_STD_LO,
    SEL_ID_LO,
    SEL_EXT_HI,
    SEL_EXT_LO
  } sel_mode_t;
endpackage

// File: rtl/padmux_field_sel.sv
module padmux_field_sel
  import padmux_pkg::*;
#(
  parameter int PH_W      = PHASE_W,
  parameter int ID_PHASE  = 2,
  parameter int EXT_PHASE = 3,
  parameter int FW        = FIELD_W
) (
  input  pad_btn_t        btn_i,
  input  logic            th_i,
  input  logic            six_en_i,
  input  logic [PH_W-1:0] phase_i,
  output logic [FW-1:0]   field_o
);
  localparam logic [PH_W-1:0] ID_PH  = PH_W'(ID_PHASE);
  localparam logic [PH_W-1:0] EXT_PH = PH_W'(EXT_PHASE);

  pad_btn_t  nb;
  sel_mode_t mode;

  always_comb begin
    nb = ~btn_i;
    if (six_en_i && phase_i == EXT_PH)
      mode = th_i ? SEL_EXT_HI : SEL_EXT_LO;
    else if (six_en_i && phase_i == ID_PH && !th_i)
      mode = SEL_ID_LO;
    else
      mode = th_i ? SEL_STD_HI : SEL_STD_LO;
  end

  always_comb begin
    unique case (mode)
      SEL_STD_HI: field_o = {nb.c, nb.b, nb.right, nb.left, nb.down, nb.up};
      SEL_STD_LO: field_o = {nb.start, nb.a, 2'b00, nb.down, nb.up};
      SEL_ID_LO:  field_o = {nb.start, nb.a, 4'b0000};
      SEL_EXT_HI: field_o = {nb.c, nb.b, nb.mode, nb.x, nb.y, nb.z};
      SEL_EXT_LO: field_o = {nb.start, nb.a, 4'b1111};
      default:    field_o = '0;
    endcase
  end

  always_comb begin
    if (!th_i)
      p_lo_start_a_r5: assert (field_o[5:4] == ~{btn_i.start, btn_i.a})
        else $error("TH low field lacks Start/A");
    if (six_en_i && phase_i == ID_PH && !th_i)
      p_id_zero_r6: assert (field_o[3:0] == 4'h0)
        else $error("id phase nibble not zero");
    if (six_en_i && phase_i == EXT_PH && th_i)
      p_ext_btn_r7: assert (field_o[3:0] == ~{btn_i.mode, btn_i.x, btn_i.y, btn_i.z})
        else $error("extended buttons misplaced");
    if (six_en_i && phase_i == EXT_PH && !th_i)
      p_ext_ones_r8: assert (field_o[3:0] == 4'hF)
        else $error("ext phase nibble not ones");
    if (th_i && !(six_en_i && phase_i == EXT_PH))
      p_std_hi_r4: assert (field_o == ~{btn_i.c, btn_i.b, btn_i.right,
                                         btn_i.left, btn_i.down, btn_i.up})
        else $error("standard TH high field wrong");
  end
endmodule

// File: rtl/padmux_port_merge.sv
module padmux_port_merge #(
  parameter int          W        = 8,
  parameter int          FW       = 6,
  parameter logic [W-1:0] OUT_FORCE = 8'h80
) (
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  dir_i,
  input  logic [FW-1:0] field_i,
  output logic [W-1:0]  port_o
);
  logic [W-1:0] out_mask;
  assign out_mask = dir_i | OUT_FORCE;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < FW) begin : g_btn
      assign port_o[i] = out_mask[i] ? data_i[i] : field_i[i];
    end else begin : g_hi
      assign port_o[i] = out_mask[i] ? data_i[i] : 1'b0;
    end
  end
endmodule

// File: rtl/padmux_port_rd.sv
module padmux_port_rd
  import padmux_pkg::*;
#(
  parameter int TH_BIT = 6
) (
  input  logic [BTN_W-1:0]   btn_i,
  input  logic [PORT_W-1:0]  data_reg_i,
  input  logic [PORT_W-1:0]  dir_reg_i,
  input  logic               six_btn_en_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [PORT_W-1:0]  port_rd_o
);
  logic [FIELD_W-1:0] field;
  pad_btn_t           btn;

  assign btn = pad_btn_t'(btn_i);

  padmux_field_sel #(
    .PH_W(PHASE_W), .ID_PHASE(2), .EXT_PHASE(3), .FW(FIELD_W)
  ) u_sel (
    .btn_i   (btn),
    .th_i    (data_reg_i[TH_BIT]),
    .six_en_i(six_btn_en_i),
    .phase_i (phase_i),
    .field_o (field)
  );

  padmux_port_merge #(
    .W(PORT_W), .FW(FIELD_W), .OUT_FORCE(8'h80)
  ) u_merge (
    .data_i (data_reg_i),
    .dir_i  (dir_reg_i),
    .field_i(field),
    .port_o (port_rd_o)
  );

  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      if (dir_reg_i[i])
        p_dir_readback_r2: assert (port_rd_o[i] == data_reg_i[i])
          else $error("output bit not read back");
    end
    p_bit7_r3: assert (port_rd_o[PORT_W-1] == data_reg_i[PORT_W-1])
      else $error("bit 7 not from data register");
    if (!dir_reg_i[TH_BIT])
      p_th_input_r10: assert (port_rd_o[TH_BIT] == 1'b0)
        else $error("TH input bit not zero");
  end
endmodule

// File: tb/padmux_port_rd_tb.sv
module padmux_port_rd_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] btn;
  logic [7:0]  dreg, dir;
  logic        six;
  logic [1:0]  ph;
  logic [7:0]  rd;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  padmux_port_rd u_dut (
    .btn_i(btn), .data_reg_i(dreg), .dir_reg_i(dir),
    .six_btn_en_i(six), .phase_i(ph), .port_rd_o(rd)
  );

  function automatic logic [7:0] model(input logic [11:0] b, input logic [7:0] d,
                                       input logic [7:0] m, input logic s,
                                       input logic [1:0] p);
    logic [11:0] n;
    logic [5:0]  f;
    logic [7:0]  msk, r;
    logic        th;
    n  = ~b;
    th = d[6];
    if (s && p == 2'd3 && th)       f = {n[5], n[4], n[11], n[10], n[9], n[8]}; // R7
    else if (s && p == 2'd3)        f = {n[7], n[6], 4'hF};                   // R8
    else if (s && p == 2'd2 && !th) f = {n[7], n[6], 4'h0};                   // R6
    else if (th)                    f = n[5:0];                               // R4
    else                            f = {n[7], n[6], 2'b00, n[1:0]};          // R5
    msk = m | 8'h80;
    for (int i = 0; i < 8; i++)
      r[i] = msk[i] ? d[i] : (i < 6 ? f[i] : 1'b0);
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] d, input logic s, input logic [1:0] p);
    if (s && p == 2'd3) return d[6] ? "R7" : "R8";
    if (s && p == 2'd2 && !d[6]) return "R6";
    if (s) return "R9";
    return d[6] ? "R4" : "R5";
  endfunction

  task automatic apply(input logic [11:0] b, input logic [7:0] d, input logic [7:0] m,
                       input logic s, input logic [1:0] p, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    btn = b; dreg = d; dir = m; six = s; ph = p;
    #1;
    exp = model(b, d, m, s, p);
    n_chk++;
    if (rd !== exp) begin
      n_fail++;
      $display("FAIL %s: btn=%h data=%h dir=%h six=%b ph=%0d got %h expected %h",
               tag, b, d, m, s, p, rd, exp);
    end
  endtask

  initial begin
    btn = '0; dreg = '0; dir = '0; six = 1'b0; ph = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-time state: TH low, nothing pressed -> R5 gives 8'h33
    @(negedge clk);
    n_chk++;
    if (rd !== 8'h33) begin
      n_fail++;
      $display("FAIL R5 reset state: got %h expected %h", rd, 8'h33);
    end
    // R1: all pressed vs none, TH high standard
    apply(12'hFFF, 8'h40, 8'h00, 1'b0, 2'd0, "R1");
    apply(12'h000, 8'h40, 8'h00, 1'b0, 2'd0, "R1");
    // R1/R4/R5/R7: walking single button across encodings
    for (int i = 0; i < 12; i++) begin
      apply(12'(1 << i), 8'h40, 8'h40, 1'b0, 2'd0, "R4");
      apply(12'(1 << i), 8'h00, 8'h40, 1'b0, 2'd1, "R5");
      apply(12'(1 << i), 8'h40, 8'h40, 1'b1, 2'd3, "R7");
      apply(12'(1 << i), 8'h00, 8'h40, 1'b1, 2'd3, "R8");
      apply(12'(1 << i), 8'h00, 8'h40, 1'b1, 2'd2, "R6");
    end
    // R6/R8 nibble constants with nothing pressed
    apply(12'h000, 8'h00, 8'h40, 1'b1, 2'd2, "R6");
    apply(12'h000, 8'h00, 8'h40, 1'b1, 2'd3, "R8");
    // R9: six enabled in phases 0,1 and phase 2 TH high; six disabled phase 3
    apply(12'hA5C, 8'h40, 8'h40, 1'b1, 2'd0, "R9");
    apply(12'hA5C, 8'h00, 8'h40, 1'b1, 2'd1, "R9");
    apply(12'hA5C, 8'h40, 8'h40, 1'b1, 2'd2, "R9");
    apply(12'hA5C, 8'h40, 8'h40, 1'b0, 2'd3, "R9");
    apply(12'hA5C, 8'h00, 8'h40, 1'b0, 2'd2, "R9");
    // R2: all outputs read data register
    apply(12'hFFF, 8'h96, 8'hFF, 1'b1, 2'd3, "R2");
    apply(12'h000, 8'h69, 8'h3F, 1'b0, 2'd0, "R2");
    // R3: bit 7 from data even when direction bit 7 is 0
    apply(12'h000, 8'hC0, 8'h00, 1'b0, 2'd0, "R3");
    apply(12'hFFF, 8'h7F, 8'h00, 1'b1, 2'd3, "R3");
    // R10: TH as input reads 0 but still selects
    apply(12'h000, 8'h40, 8'h00, 1'b1, 2'd3, "R10");
    apply(12'h000, 8'h00, 8'h00, 1'b1, 2'd3, "R10");
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] b;
      logic [7:0]  d, m;
      logic        s;
      logic [1:0]  p;
      b = 12'($urandom);
      d = 8'($urandom);
      m = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h40;
      s = ($urandom_range(0, 3) != 0);
      p = 2'($urandom);
      apply(b, d, m, s, p, tag_of(d, s, p));
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule